// File: doc/BRIEF.md
# Multiplexed Pixel Port Unpacker

This block sits between a wide, slow pixel bus and a colour path that takes one pixel per pixel-clock cycle. The bus carries four 24-bit lanes at once, each holding red, green and blue bytes. A rising edge on the load strobe captures the whole word, together with a two-bit palette-select field per lane and the word-level blank, sync and field flags. Over the following cycles the block hands out the lanes one at a time. The multiplex ratio can be 2:1, 4:1 or, for 8-bit indexed colour only, 8:1. In 8:1 mode each lane is read as three separate 8-bit indices.

The block also generates a load-out strobe at the pixel clock divided by the active ratio. Looped back, directly or through logic, to the load input, it paces the upstream frame store. The ratio and pixel-format settings are sampled only at a capture. Changing them while a word is being emitted has no effect until the next load edge, and that edge also restarts the lane and divider counts.

Top module: `pixmux_unpack`

## Requirements
- R1: In reset and after reset, until the first load edge, `pix_valid` is 0 and all pixel outputs are 0. In reset `load_out` is 1.
- R2: A word is captured only when `load_in` is 1 at a clock edge and was 0 at the previous edge. The first pixel (lane A) is on the outputs with `pix_valid`=1 after that same edge. Holding `load_in` high captures nothing further.
- R3: With `ratio_sel`=1 (4:1), the lanes come out in the order A, B, C, D on consecutive cycles, and `pix_valid` falls in the cycle after D unless a new word is loaded. Lane n occupies `pix_bus[24n+23:24n]`.
- R4: With `ratio_sel`=0 (2:1), only lanes A and B are emitted.
- R5: With `ratio_sel`=2 and `fmt_sel`=3, eight indices are emitted in this order: A red, A green, A blue, B red, B green, B blue, C red, C green. Each index appears on all three colour outputs.
- R6: `ratio_sel`=2 with any `fmt_sel` other than 3, and `ratio_sel`=3, both behave as 4:1.
- R7: `fmt_sel`=0 (24-bit): red, green and blue are lane bits [23:16], [15:8] and [7:0].
- R8: `fmt_sel`=1 (16-bit 5:6:5 in lane bits [15:0]): red={l[15:11],l[15:13]}, green={l[10:5],l[10:9]}, blue={l[4:0],l[4:2]}.
- R9: `fmt_sel`=2 (15-bit 5:5:5 in lane bits [14:0]): red={l[14:10],l[14:12]}, green={l[9:5],l[9:7]}, blue={l[4:0],l[4:2]}.
- R10: `fmt_sel`=3 at 2:1 or 4:1: the index is lane bits [23:16], driven on all three colour outputs.
- R11: `pix_psel` is `psel_bus[2n+1:2n]` for the lane n that the pixel came from. `pix_blank`, `pix_sync` and `pix_field` carry the captured flags and hold them for every pixel of the word.
- R12: `load_out` is 1 while the divider phase is below M/2. The phase counts 0 to M-1 and wraps, and a capture edge sets it to 1. M is the active ratio (2, 4 or 8).
- R13: Changes to `ratio_sel` or `fmt_sel` made after a capture do not alter the pixels or the pixel count of the word already captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_in | input | 1 | Load strobe; rising edge captures the word |
| pix_bus | input | 96 | Four 24-bit lanes, lane A in the low bits |
| psel_bus | input | 8 | Two palette-select bits per lane |
| blank_in | input | 1 | Blank flag for the word |
| sync_in | input | 1 | Sync flag for the word |
| field_in | input | 1 | Odd/even field flag for the word |
| ratio_sel | input | 2 | 0: 2:1, 1: 4:1, 2: 8:1, 3: treated as 4:1 |
| fmt_sel | input | 2 | 0: 24-bit, 1: 16-bit, 2: 15-bit, 3: 8-bit index |
| load_out | output | 1 | Divided load strobe, period M |
| pix_valid | output | 1 | A pixel is on the outputs this cycle |
| pix_red | output | 8 | Red channel or index |
| pix_grn | output | 8 | Green channel or index |
| pix_blu | output | 8 | Blue channel or index |
| pix_psel | output | 2 | Palette select of the source lane |
| pix_blank | output | 1 | Captured blank flag |
| pix_sync | output | 1 | Captured sync flag |
| pix_field | output | 1 | Captured field flag |

## Verification
The bench targets four corner cases.

- **8:1 byte walk.** A lane split taken as lane = index with no division into bytes would emit the wrong bytes, or run past lane C.
- **Illegal 8:1 requests.** An 8:1 request outside indexed colour, or the reserved ratio code, must not produce eight pixels. A decoder that trusted the code would emit them.
- **Level versus edge on the load strobe.** A strobe held high must not reload the word. A level-sensitive capture would repeat lane A forever.
- **Settings changed mid-word.** The ratio and format are switched in the middle of a word. A design that read them live would cut the word short or change its colour expansion.

The phase of `load_out` after a capture is also checked at every ratio. An off-by-one restart value in the divider shifts the whole pattern by one cycle.

// File: rtl/pixmux_pkg.sv
// Package: shared encodings for the pixel port unpacker.
// Assumes the 2-bit ratio and format codes given in the brief.
package pixmux_pkg;

    typedef enum logic [1:0] {
        RATIO_2   = 2'd0,
        RATIO_4   = 2'd1,
        RATIO_8   = 2'd2,
        RATIO_RSV = 2'd3
    } ratio_e;

    typedef enum logic [1:0] {
        FMT_TRUE24 = 2'd0,
        FMT_TRUE16 = 2'd1,
        FMT_TRUE15 = 2'd2,
        FMT_INDEX8 = 2'd3
    } fmt_e;

    // Effective log2 of the ratio: 8:1 only with indexed colour, else 4:1 (R6)
    function automatic logic [1:0] eff_lg(input logic [1:0] rs, input logic [1:0] fs);
        logic [1:0] lg;
        case (rs)
            RATIO_2: lg = 2'd1;
            RATIO_8: lg = (fs == FMT_INDEX8) ? 2'd3 : 2'd2;
            default: lg = 2'd2;
        endcase
        return lg;
    endfunction

endpackage

// File: rtl/pixmux_lane_pick.sv
// Module: pixmux_lane_pick
// Combinational selection of one pixel from a captured word and its colour
// expansion. Assumes CHAN_W = 8 for the 16-bit and 15-bit expansions and
// at least three lanes when the 8:1 byte walk is used.
module pixmux_lane_pick
    import pixmux_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int LANES  = 4,
    parameter int PS_W   = 2,
    localparam int LANE_W  = 3 * CHAN_W,
    localparam int BUS_W   = LANES * LANE_W,
    localparam int LANE_IW = $clog2(LANES)
) (
    input  logic [BUS_W-1:0]      word,
    input  logic [LANES*PS_W-1:0] ps_word,
    input  logic [3:0]            idx,
    input  logic [1:0]            lg,
    input  logic [1:0]            fmt,
    output logic [CHAN_W-1:0]     red,
    output logic [CHAN_W-1:0]     grn,
    output logic [CHAN_W-1:0]     blu,
    output logic [PS_W-1:0]       ps
);

    logic [LANE_W-1:0]  lanes   [LANES];
    logic [PS_W-1:0]    ps_lane [LANES];
    logic [LANE_IW-1:0] lane_num;
    logic [1:0]         byte_num;
    logic [LANE_W-1:0]  ln;
    logic [CHAN_W-1:0]  index;

    // Split the flat bus into lanes, lane A in the low bits
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i]   = word[i*LANE_W +: LANE_W];
        assign ps_lane[i] = ps_word[i*PS_W +: PS_W];
    end

    // Map the emit index to a lane and a byte (byte walk in 8:1, R5)
    always_comb begin
        if (lg == 2'd3) begin
            if (idx >= 4'd6) begin
                lane_num = LANE_IW'(2);
                byte_num = 2'(idx - 4'd6);
            end else if (idx >= 4'd3) begin
                lane_num = LANE_IW'(1);
                byte_num = 2'(idx - 4'd3);
            end else begin
                lane_num = '0;
                byte_num = 2'(idx);
            end
        end else begin
            lane_num = LANE_IW'(idx);
            byte_num = 2'd0;
        end
    end

    assign ln = lanes[lane_num];
    assign ps = ps_lane[lane_num];

    // Choose the index byte: red first, then green, then blue
    always_comb begin
        case (byte_num)
            2'd1:    index = ln[2*CHAN_W-1:CHAN_W];
            2'd2:    index = ln[CHAN_W-1:0];
            default: index = ln[3*CHAN_W-1:2*CHAN_W];
        endcase
    end

    // Expand the lane into three channels according to the format
    always_comb begin
        case (fmt)
            FMT_TRUE16: begin
                red = {ln[15:11], ln[15:13]};
                grn = {ln[10:5],  ln[10:9]};
                blu = {ln[4:0],   ln[4:2]};
            end
            FMT_TRUE15: begin
                red = {ln[14:10], ln[14:12]};
                grn = {ln[9:5],   ln[9:7]};
                blu = {ln[4:0],   ln[4:2]};
            end
            FMT_INDEX8: begin
                red = index;
                grn = index;
                blu = index;
            end
            default: begin
                red = ln[3*CHAN_W-1:2*CHAN_W];
                grn = ln[2*CHAN_W-1:CHAN_W];
                blu = ln[CHAN_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/pixmux_seq.sv
// Module: pixmux_seq
// Detects the load edge, captures the word with its control bits and the
// settings, and counts the emit index. Assumes load_in is synchronous to clk.
module pixmux_seq
    import pixmux_pkg::*;
#(
    parameter int BUS_W  = 96,
    parameter int PSB_W  = 8,
    parameter int CTL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_in,
    input  logic [BUS_W-1:0] bus,
    input  logic [PSB_W-1:0] ps_in,
    input  logic [CTL_W-1:0] ctl_in,
    input  logic [1:0]       ratio_sel,
    input  logic [1:0]       fmt_sel,
    output logic             cap,
    output logic             emit,
    output logic [BUS_W-1:0] src_word,
    output logic [PSB_W-1:0] src_ps,
    output logic [CTL_W-1:0] src_ctl,
    output logic [3:0]       src_idx,
    output logic [1:0]       src_lg,
    output logic [1:0]       src_fmt,
    output logic [1:0]       act_lg
);

    logic             load_q;
    logic [BUS_W-1:0] word_q;
    logic [PSB_W-1:0] ps_q;
    logic [CTL_W-1:0] ctl_q;
    logic [1:0]       lg_q;
    logic [1:0]       fmt_q;
    logic [3:0]       sel_q;
    logic [3:0]       m_cur;
    logic [1:0]       new_lg;

    assign cap    = load_in & ~load_q;
    assign new_lg = eff_lg(ratio_sel, fmt_sel);
    assign m_cur  = 4'd1 << lg_q;
    assign emit   = cap | (sel_q < m_cur);

    assign src_word = cap ? bus       : word_q;
    assign src_ps   = cap ? ps_in     : ps_q;
    assign src_ctl  = cap ? ctl_in    : ctl_q;
    assign src_idx  = cap ? 4'd0      : sel_q;
    assign src_lg   = cap ? new_lg    : lg_q;
    assign src_fmt  = cap ? fmt_sel   : fmt_q;
    assign act_lg   = lg_q;

    // Capture word and settings on a load edge, then step the emit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            word_q <= '0;
            ps_q   <= '0;
            ctl_q  <= '0;
            lg_q   <= 2'd1;
            fmt_q  <= 2'd0;
            sel_q  <= 4'hF;
        end else begin
            load_q <= load_in;
            if (cap) begin
                word_q <= bus;
                ps_q   <= ps_in;
                ctl_q  <= ctl_in;
                lg_q   <= new_lg;
                fmt_q  <= fmt_sel;
                sel_q  <= 4'd1;
            end else if (sel_q < m_cur) begin
                sel_q  <= sel_q + 4'd1;
            end
        end
    end

endmodule

// File: rtl/pixmux_div.sv
// Module: pixmux_div
// Divides the pixel clock by the active ratio to make load_out. Assumes the
// ratio only changes on a capture, which also restarts the phase at 1.
module pixmux_div #(
    parameter int PH_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] lg,
    output logic       load_out
);

    logic [PH_W-1:0] ph;
    logic [PH_W:0]   m_val;
    logic            last;

    assign m_val    = (PH_W+1)'(1) << lg;
    assign last     = ({1'b0, ph} == m_val - (PH_W+1)'(1));
    assign load_out = ({1'b0, ph} < (m_val >> 1));

    // Advance the phase modulo M; a capture aligns it to 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (restart) begin
            ph <= PH_W'(1);
        end else if (last) begin
            ph <= '0;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

endmodule

// File: rtl/pixmux_unpack.sv
// Module: pixmux_unpack (top)
// Captures a multi-lane pixel word on a load edge and emits one pixel per
// clock at 2:1, 4:1 or 8:1, with a divided load-out strobe. Outputs are
// registered. Assumes all inputs are synchronous to clk.
module pixmux_unpack #(
    parameter int CHAN_W = 8,
    parameter int LANES  = 4,
    parameter int PS_W   = 2,
    localparam int LANE_W = 3 * CHAN_W,
    localparam int BUS_W  = LANES * LANE_W,
    localparam int PSB_W  = LANES * PS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_in,
    input  logic [BUS_W-1:0]  pix_bus,
    input  logic [PSB_W-1:0]  psel_bus,
    input  logic              blank_in,
    input  logic              sync_in,
    input  logic              field_in,
    input  logic [1:0]        ratio_sel,
    input  logic [1:0]        fmt_sel,
    output logic              load_out,
    output logic              pix_valid,
    output logic [CHAN_W-1:0] pix_red,
    output logic [CHAN_W-1:0] pix_grn,
    output logic [CHAN_W-1:0] pix_blu,
    output logic [PS_W-1:0]   pix_psel,
    output logic              pix_blank,
    output logic              pix_sync,
    output logic              pix_field
);

    logic              cap;
    logic              emit;
    logic [BUS_W-1:0]  src_word;
    logic [PSB_W-1:0]  src_ps;
    logic [2:0]        src_ctl;
    logic [3:0]        src_idx;
    logic [1:0]        src_lg;
    logic [1:0]        src_fmt;
    logic [1:0]        act_lg;
    logic [CHAN_W-1:0] nx_red;
    logic [CHAN_W-1:0] nx_grn;
    logic [CHAN_W-1:0] nx_blu;
    logic [PS_W-1:0]   nx_ps;

    pixmux_seq #(
        .BUS_W (BUS_W),
        .PSB_W (PSB_W),
        .CTL_W (3)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_in   (load_in),
        .bus       (pix_bus),
        .ps_in     (psel_bus),
        .ctl_in    ({blank_in, sync_in, field_in}),
        .ratio_sel (ratio_sel),
        .fmt_sel   (fmt_sel),
        .cap       (cap),
        .emit      (emit),
        .src_word  (src_word),
        .src_ps    (src_ps),
        .src_ctl   (src_ctl),
        .src_idx   (src_idx),
        .src_lg    (src_lg),
        .src_fmt   (src_fmt),
        .act_lg    (act_lg)
    );

    pixmux_lane_pick #(
        .CHAN_W (CHAN_W),
        .LANES  (LANES),
        .PS_W   (PS_W)
    ) i_pick (
        .word    (src_word),
        .ps_word (src_ps),
        .idx     (src_idx),
        .lg      (src_lg),
        .fmt     (src_fmt),
        .red     (nx_red),
        .grn     (nx_grn),
        .blu     (nx_blu),
        .ps      (nx_ps)
    );

    pixmux_div #(
        .PH_W (3)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cap),
        .lg       (act_lg),
        .load_out (load_out)
    );

    // Register the selected pixel and its flags onto the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_red   <= '0;
            pix_grn   <= '0;
            pix_blu   <= '0;
            pix_psel  <= '0;
            pix_blank <= 1'b0;
            pix_sync  <= 1'b0;
            pix_field <= 1'b0;
        end else begin
            pix_valid <= emit;
            if (emit) begin
                pix_red   <= nx_red;
                pix_grn   <= nx_grn;
                pix_blu   <= nx_blu;
                pix_psel  <= nx_ps;
                pix_blank <= src_ctl[2];
                pix_sync  <= src_ctl[1];
                pix_field <= src_ctl[0];
            end
        end
    end

endmodule

// File: rtl/pixmux_unpack_chk.sv
// Module: pixmux_unpack_chk
// Property checker bound to the top. Tracks load edges with its own
// registers and checks the valid window and the flag hold behaviour.
module pixmux_unpack_chk (
    input logic clk,
    input logic rst_n,
    input logic load_in,
    input logic pix_valid,
    input logic pix_blank,
    input logic pix_sync,
    input logic pix_field
);

    logic       prev_q;
    logic       seen_q;
    logic [3:0] since_q;
    logic       rise;

    assign rise = load_in && !prev_q;

    // Track the last load edge and the cycles elapsed since it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            seen_q  <= 1'b0;
            since_q <= 4'hF;
        end else begin
            prev_q <= load_in;
            if (rise) begin
                seen_q  <= 1'b1;
                since_q <= 4'd0;
            end else if (since_q != 4'hF) begin
                since_q <= since_q + 4'd1;
            end
        end
    end

    // R1: no pixel before the first load edge
    a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> seen_q);

    // R2: a load edge puts a pixel on the outputs after that edge
    a_r2_capture_emits: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pix_valid);

    // R3: no word yields more than eight pixels
    a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (since_q < 4'd8));

    // R11: flags stay fixed across the pixels of one word
    a_r11_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && !$past(rise))
            |-> $stable({pix_blank, pix_sync, pix_field}));

endmodule

bind pixmux_unpack pixmux_unpack_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_in   (load_in),
    .pix_valid (pix_valid),
    .pix_blank (pix_blank),
    .pix_sync  (pix_sync),
    .pix_field (pix_field)
);

// File: tb/test_pixmux_unpack.sv
`timescale 1ns/1ps
// Bench for pixmux_unpack: a vector table walked by one loop, then directed
// tests for reset, strobe level, mid-word setting changes and load_out phase.
module test_pixmux_unpack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_in = 1'b0;
    logic [95:0] pix_bus = '0;
    logic [7:0]  psel_bus = '0;
    logic        blank_in = 1'b0;
    logic        sync_in = 1'b0;
    logic        field_in = 1'b0;
    logic [1:0]  ratio_sel = 2'd1;
    logic [1:0]  fmt_sel = 2'd0;
    logic        load_out;
    logic        pix_valid;
    logic [7:0]  pix_red;
    logic [7:0]  pix_grn;
    logic [7:0]  pix_blu;
    logic [1:0]  pix_psel;
    logic        pix_blank;
    logic        pix_sync;
    logic        pix_field;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pixmux_unpack i_pixmux_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_in   (load_in),
        .pix_bus   (pix_bus),
        .psel_bus  (psel_bus),
        .blank_in  (blank_in),
        .sync_in   (sync_in),
        .field_in  (field_in),
        .ratio_sel (ratio_sel),
        .fmt_sel   (fmt_sel),
        .load_out  (load_out),
        .pix_valid (pix_valid),
        .pix_red   (pix_red),
        .pix_grn   (pix_grn),
        .pix_blu   (pix_blu),
        .pix_psel  (pix_psel),
        .pix_blank (pix_blank),
        .pix_sync  (pix_sync),
        .pix_field (pix_field)
    );

    typedef struct packed {
        logic [1:0] rs;
        logic [1:0] fs;
        logic [7:0] seed;
        logic [2:0] ctl;
        logic [7:0] ps;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 2'd0, 8'h11, 3'b101, 8'hE4},
        '{2'd0, 2'd0, 8'h3C, 3'b010, 8'h1B},
        '{2'd2, 2'd3, 8'h05, 3'b001, 8'hE4},
        '{2'd1, 2'd1, 8'hA7, 3'b110, 8'h4E},
        '{2'd1, 2'd2, 8'h5D, 3'b011, 8'hB1},
        '{2'd1, 2'd3, 8'h92, 3'b100, 8'h27},
        '{2'd2, 2'd0, 8'h68, 3'b111, 8'hD8},
        '{2'd3, 2'd2, 8'hC3, 3'b000, 8'h93},
        '{2'd0, 2'd3, 8'h2F, 3'b101, 8'h6C},
        '{2'd2, 2'd3, 8'hF0, 3'b010, 8'h39}
    };

    // Word pattern: byte j of the bus is seed + 29*j
    function automatic logic [95:0] mk_bus(input logic [7:0] seed);
        logic [95:0] b;
        for (int j = 0; j < 12; j++) b[8*j +: 8] = seed + 8'(29 * j);
        return b;
    endfunction

    // Pixels per word from R4, R5, R6
    function automatic int ref_cnt(input logic [1:0] rs, input logic [1:0] fs);
        if (rs == 2'd0) return 2;
        if (rs == 2'd2 && fs == 2'd3) return 8;
        return 4;
    endfunction

    // Expected {psel, red, green, blue} from R3..R11
    function automatic logic [25:0] ref_pix(input logic [95:0] b, input logic [7:0] ps,
                                            input logic [1:0] rs, input logic [1:0] fs,
                                            input int k);
        int lane;
        int bi;
        logic [23:0] l;
        logic [7:0] r, g, bl, ix;
        if (ref_cnt(rs, fs) == 8) begin
            lane = k / 3;
            bi   = k % 3;
        end else begin
            lane = k;
            bi   = 0;
        end
        l  = b[lane*24 +: 24];
        ix = (bi == 0) ? l[23:16] : (bi == 1) ? l[15:8] : l[7:0];
        case (fs)
            2'd1: begin r = {l[15:11], l[15:13]}; g = {l[10:5], l[10:9]}; bl = {l[4:0], l[4:2]}; end
            2'd2: begin r = {l[14:10], l[14:12]}; g = {l[9:5], l[9:7]}; bl = {l[4:0], l[4:2]}; end
            2'd3: begin r = ix; g = ix; bl = ix; end
            default: begin r = l[23:16]; g = l[15:8]; bl = l[7:0]; end
        endcase
        return {ps[lane*2 +: 2], r, g, bl};
    endfunction

    function automatic string tag_of(input logic [1:0] rs, input logic [1:0] fs);
        string t;
        case (fs)
            2'd1: t = "R8";
            2'd2: t = "R9";
            2'd3: t = (rs == 2'd2) ? "R5" : "R10";
            default: t = "R7";
        endcase
        if ((rs == 2'd2 && fs != 2'd3) || rs == 2'd3) t = {t, "/R6"};
        else if (rs == 2'd0) t = {t, "/R4"};
        else t = {t, "/R3"};
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Load one word and check every emitted pixel and the end of the run
    task automatic run_word(input vec_t v);
        logic [95:0] b;
        int n;
        b = mk_bus(v.seed);
        n = ref_cnt(v.rs, v.fs);
        @(negedge clk);
        pix_bus   = b;
        psel_bus  = v.ps;
        {blank_in, sync_in, field_in} = v.ctl;
        ratio_sel = v.rs;
        fmt_sel   = v.fs;
        load_in   = 1'b1;
        @(negedge clk);
        load_in = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            check({"R2 valid ", tag_of(v.rs, v.fs)}, 32'(pix_valid), 32'd1);
            check(tag_of(v.rs, v.fs), 32'({pix_psel, pix_red, pix_grn, pix_blu}),
                  32'(ref_pix(b, v.ps, v.rs, v.fs, k)));
            check("R11 flags", 32'({pix_blank, pix_sync, pix_field}), 32'(v.ctl));
        end
        @(negedge clk);
        check({"count ", tag_of(v.rs, v.fs)}, 32'(pix_valid), 32'd0);
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(pix_valid), 32'd0);
        check("R1 load_out in reset", 32'(load_out), 32'd1);
        check("R1 pixel in reset", 32'({pix_red, pix_grn, pix_blu}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", 32'(pix_valid), 32'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) run_word(VEC[i]);

        // R2: strobe held high captures once only
        begin
            int cnt;
            cnt = 0;
            @(negedge clk);
            ratio_sel = 2'd1;
            fmt_sel   = 2'd0;
            load_in   = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (pix_valid) cnt++;
            end
            check("R2 held strobe pixel count", 32'(cnt), 32'd4);
            load_in = 1'b0;
            @(negedge clk);
        end

        // R13: settings changed mid-word do not affect the current word
        begin
            int cnt;
            logic [95:0] b;
            logic [25:0] third;
            b = mk_bus(8'h77);
            cnt = 0;
            @(negedge clk);
            pix_bus   = b;
            psel_bus  = 8'hE4;
            ratio_sel = 2'd1;
            fmt_sel   = 2'd0;
            load_in   = 1'b1;
            @(negedge clk);
            load_in   = 1'b0;
            ratio_sel = 2'd0;
            fmt_sel   = 2'd1;
            third     = '0;
            for (int k = 0; k < 8; k++) begin
                if (k > 0) @(negedge clk);
                if (pix_valid) cnt++;
                if (k == 2) third = {pix_psel, pix_red, pix_grn, pix_blu};
            end
            check("R13 pixel count kept", 32'(cnt), 32'd4);
            check("R13 format kept", 32'(third), 32'(ref_pix(b, 8'hE4, 2'd1, 2'd0, 2)));
            // next word picks up the new 2:1 setting
            run_word('{2'd0, 2'd1, 8'h44, 3'b011, 8'h72});
        end

        // R12: load_out phase after a capture at each ratio
        for (int r = 0; r < 3; r++) begin
            int m;
            m = (r == 0) ? 2 : (r == 1) ? 4 : 8;
            @(negedge clk);
            ratio_sel = 2'(r);
            fmt_sel   = 2'd3;
            load_in   = 1'b1;
            @(negedge clk);
            load_in = 1'b0;
            for (int k = 0; k < 2 * m; k++) begin
                if (k > 0) @(negedge clk);
                check("R12 load_out phase", 32'(load_out), 32'(((1 + k) % m) < (m / 2)));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule